// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls one bank of general-purpose I/O pads. Each pad is owned either by the bank's own GPIO logic or by one of four internal peripheral functions. When GPIO owns a pad, the bank sets its output enable and output level. When a peripheral owns it, the chosen peripheral's output value and output enable are routed to the pad. Per-pad open-drain mode, pull-up, pull-down and Schmitt-trigger disable controls are also held here.

Software reaches the bank through a simple single-word register bus. Writes take effect at once. Reads return data one cycle after the address is presented. Ownership, output enable, output level, open-drain, pull-up and pull-down each have three registers:
- a write-1-to-set register,
- a write-1-to-clear register,
- a read-only status register.

Writing 0 bits to a set or clear register leaves those pins unchanged. Two plain read-write registers hold the peripheral select code, and a third holds the Schmitt-trigger disable bits. A pin-level register reads back the live pad inputs whatever the mux setting. All pad-side outputs are registered, so they follow a register change by one clock.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, every status register reads as follows:
  - ownership (word 0x02) reads all ones;
  - pull-up (0x12) reads all ones;
  - output enable (0x06), level (0x0A), open-drain (0x0E) and pull-down (0x16) read zero;
  - both select registers (0x18, 0x19) and the Schmitt register (0x1A) read zero;
  - pad_oe and pad_pd are all zero and pad_pu is all ones.
- R2: Writing 1s to word 0x00 gives those pins to GPIO, and writing 1s to word 0x01 gives them to a peripheral. Word 0x02 reads 1 for each GPIO-owned pin.
- R3: Output enable is set at 0x04, cleared at 0x05 and read at 0x06. On a GPIO-owned pin that is not open-drain, pad_oe equals the enable bit one cycle after the register changes.
- R4: Output level is set at 0x08, cleared at 0x09 and read at 0x0A. Only the bits written as 1 change. On a GPIO-owned pin, pad_out follows the level bit.
- R5: A peripheral-owned pin takes its function from the code {bit of 0x19, bit of 0x18}: 0 selects A, 1 selects B, 2 selects C and 3 selects D. Function k drives pad p from periph_out[k*32+p] and periph_oe[k*32+p].
- R6: Word 0x1B returns pad_in for every pin, including peripheral-owned pins.
- R7: Open-drain is set at 0x0C, cleared at 0x0D and read at 0x0E. On an open-drain pin, pad_out is 0, and pad_oe is 1 only when the selected output is enabled and low.
- R8: Pull-up is set at 0x10, cleared at 0x11 and read at 0x12. Pull-down is set at 0x14, cleared at 0x15 and read at 0x16.
- R9: pad_pu and pad_pd are never both 1 on the same pin: when both pulls are enabled, pull-up wins. Word 0x1C reads 1 for each pin that has both pulls enabled.
- R10: Word 0x1A is read-write, and each 1 bit drives pad_st_off high for that pin one cycle after the write.
- R11: Writes to status words (0x02, 0x06, 0x0A, 0x0E, 0x12, 0x16, 0x1B, 0x1C) and to unmapped words have no effect. Reads of unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| pad_in | input | 32 | Live pad levels |
| periph_out | input | 128 | Output values of functions A..D, 32 bits each |
| periph_oe | input | 128 | Output enables of functions A..D, 32 bits each |
| pad_out | output | 32 | Registered pad output value |
| pad_oe | output | 32 | Registered pad output enable |
| pad_pu | output | 32 | Registered pull-up enable |
| pad_pd | output | 32 | Registered pull-down enable |
| pad_st_off | output | 32 | Registered Schmitt-trigger disable |

## Verification
The assertions assume the following about the inputs:
- reset is held for at least one clock at the start;
- a write and its address are stable across the sampling edge.

They make no assumption about the peripheral or pad inputs, because the pull exclusion and the open-drain low-only drive must hold for any peripheral values. The stimulus changes inputs only on falling edges and asserts reset before anything else. The peripheral buses are driven with both one-hot and inverted patterns, so that every select code is seen choosing both a 1 and a 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NUM_FUNC = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_FUNC);
  localparam int unsigned NUM_PAIR = 6;
  localparam int unsigned ADDR_W   = 5;

  // Set/clear pair index; pair k uses words k*4 (set), k*4+1 (clear), k*4+2 (status).
  localparam int unsigned PR_OWN = 0;
  localparam int unsigned PR_OE  = 1;
  localparam int unsigned PR_LVL = 2;
  localparam int unsigned PR_OD  = 3;
  localparam int unsigned PR_PU  = 4;
  localparam int unsigned PR_PD  = 5;

  localparam logic [ADDR_W-1:0] A_SEL_LO   = 5'h18;
  localparam logic [ADDR_W-1:0] A_SEL_HI   = 5'h19;
  localparam logic [ADDR_W-1:0] A_ST_OFF   = 5'h1A;
  localparam logic [ADDR_W-1:0] A_PIN_LVL  = 5'h1B;
  localparam logic [ADDR_W-1:0] A_PULL_CFL = 5'h1C;

  function automatic logic pair_resets_high(int unsigned k);
    return (k == PR_OWN) || (k == PR_PU);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned N       = 32,
  parameter bit          RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  logic [N-1:0] set_m, clr_m;
  assign set_m = set_we ? wdata : '0;
  assign clr_m = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= {N{RST_ONE}};
    else     q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]          own,
  input  logic [N-1:0]          oe,
  input  logic [N-1:0]          lvl,
  input  logic [N-1:0]          od,
  input  logic [N-1:0]          pu,
  input  logic [N-1:0]          pd,
  input  logic [N-1:0]          sel_lo,
  input  logic [N-1:0]          sel_hi,
  input  logic [NUM_FUNC*N-1:0] periph_out,
  input  logic [NUM_FUNC*N-1:0] periph_oe,
  output logic [N-1:0]          drv_out,
  output logic [N-1:0]          drv_oe,
  output logic [N-1:0]          drv_pu,
  output logic [N-1:0]          drv_pd
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [SEL_W-1:0] code;
    logic             src_o, src_e;

    assign code = {sel_hi[p], sel_lo[p]};

    always_comb begin
      src_o = lvl[p];
      src_e = oe[p];
      if (!own[p]) begin
        src_o = periph_out[int'(code)*N + p];
        src_e = periph_oe[int'(code)*N + p];
      end
    end

    // Open-drain pins only ever pull low.
    assign drv_out[p] = od[p] ? 1'b0 : src_o;
    assign drv_oe[p]  = od[p] ? (src_e & ~src_o) : src_e;
    assign drv_pu[p]  = pu[p];
    assign drv_pd[p]  = pd[p] & ~pu[p];
  end
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [N-1:0]          wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [N-1:0]          rd_data,
  input  logic [N-1:0]          pad_in,
  input  logic [NUM_FUNC*N-1:0] periph_out,
  input  logic [NUM_FUNC*N-1:0] periph_oe,
  output logic [N-1:0]          pad_out,
  output logic [N-1:0]          pad_oe,
  output logic [N-1:0]          pad_pu,
  output logic [N-1:0]          pad_pd,
  output logic [N-1:0]          pad_st_off
);
  logic [NUM_PAIR-1:0][N-1:0] pair_q;
  logic [N-1:0] sel_lo_q, sel_hi_q, st_off_q;
  logic [N-1:0] drv_out, drv_oe, drv_pu, drv_pd;
  logic [N-1:0] rd_nxt;

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    logic set_we, clr_we;
    assign set_we = wr_en && (wr_addr == ADDR_W'(k*4));
    assign clr_we = wr_en && (wr_addr == ADDR_W'(k*4 + 1));
    gpio_setclr_reg #(.N(N), .RST_ONE(pair_resets_high(k))) u_reg (
      .clk(clk), .rst(rst), .set_we(set_we), .clr_we(clr_we),
      .wdata(wr_data), .q(pair_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      st_off_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SEL_LO) sel_lo_q <= wr_data;
      if (wr_addr == A_SEL_HI) sel_hi_q <= wr_data;
      if (wr_addr == A_ST_OFF) st_off_q <= wr_data;
    end
  end

  gpio_pad_drive #(.N(N)) u_drive (
    .own(pair_q[PR_OWN]), .oe(pair_q[PR_OE]), .lvl(pair_q[PR_LVL]),
    .od(pair_q[PR_OD]), .pu(pair_q[PR_PU]), .pd(pair_q[PR_PD]),
    .sel_lo(sel_lo_q), .sel_hi(sel_hi_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .drv_out(drv_out), .drv_oe(drv_oe), .drv_pu(drv_pu), .drv_pd(drv_pd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out    <= '0;
      pad_oe     <= '0;
      pad_pu     <= '1;
      pad_pd     <= '0;
      pad_st_off <= '0;
    end else begin
      pad_out    <= drv_out;
      pad_oe     <= drv_oe;
      pad_pu     <= drv_pu;
      pad_pd     <= drv_pd;
      pad_st_off <= st_off_q;
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NUM_PAIR; k++)
      if (rd_addr == ADDR_W'(k*4 + 2)) rd_nxt = pair_q[k];
    case (rd_addr)
      A_SEL_LO:   rd_nxt = sel_lo_q;
      A_SEL_HI:   rd_nxt = sel_hi_q;
      A_ST_OFF:   rd_nxt = st_off_q;
      A_PIN_LVL:  rd_nxt = pad_in;
      A_PULL_CFL: rd_nxt = pair_q[PR_PU] & pair_q[PR_PD];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [N-1:0]      own_q,
  input logic [N-1:0]      oe_q,
  input logic [N-1:0]      od_q,
  input logic [N-1:0]      pd_q,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_oe,
  input logic [N-1:0]      pad_pu,
  input logic [N-1:0]      pad_pd
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (own_q == '1) && (oe_q == '0) && (pd_q == '0));

  // R9
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  // R7
  open_drain_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(od_q) & pad_out) == '0);

  // R3
  gpio_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe ^ $past(oe_q)) & $past(own_q & ~od_q)) == '0);

  // R11
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 5'h02) |=> $stable(own_q));
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .own_q(pair_q[0]), .oe_q(pair_q[1]), .od_q(pair_q[3]), .pd_q(pair_q[5]),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/gpio_mux_bank_bench.sv
module gpio_mux_bank_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] pad_in = '0;
  logic [4*N-1:0] periph_out = '0;
  logic [4*N-1:0] periph_oe = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_off;

  int checks = 0;
  int errors = 0;
  logic rd_go = 1'b0;
  logic rd_due = 1'b0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  gpio_mux_bank #(.N(N)) u_gpio_mux_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_st_off(pad_st_off)
  );

  // Monitor: pops one expected read result per completed read.
  always @(posedge clk) rd_due <= rd_go;
  always @(negedge clk) begin
    if (rd_due && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s read got %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [N-1:0] e, input string t);
    rd_addr = a; rd_go = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pchk(input string t, input logic [N-1:0] act, input logic [N-1:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(5'h02, 32'hFFFF_FFFF, "R1 own");
    rd(5'h06, 32'h0, "R1 oe");
    rd(5'h0A, 32'h0, "R1 lvl");
    rd(5'h0E, 32'h0, "R1 od");
    rd(5'h12, 32'hFFFF_FFFF, "R1 pu");
    rd(5'h16, 32'h0, "R1 pd");
    rd(5'h18, 32'h0, "R1 sel_lo");
    rd(5'h19, 32'h0, "R1 sel_hi");
    rd(5'h1A, 32'h0, "R1 st");
    pchk("R1 pad_oe", pad_oe, 32'h0);
    pchk("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
    pchk("R1 pad_pd", pad_pd, 32'h0);

    // R4 level set/clear only touches written bits
    wr(5'h08, 32'hF0);
    wr(5'h09, 32'h10);
    rd(5'h0A, 32'hE0, "R4 lvl clr");
    wr(5'h08, 32'h1);
    rd(5'h0A, 32'hE1, "R4 lvl set");

    // R3 output enable
    wr(5'h04, 32'hFF);
    wr(5'h05, 32'h0F);
    rd(5'h06, 32'hF0, "R3 oe stat");
    settle();
    pchk("R3 pad_oe", pad_oe, 32'hF0);
    pchk("R4 pad_out", pad_out, 32'hE1);

    // R2 / R5: pins 0..3 to functions A,B,C,D
    for (int k = 0; k < 4; k++) begin
      periph_out[k*N +: N] = N'(1) << k;
      periph_oe[k*N +: N]  = '1;
    end
    wr(5'h18, 32'hA);
    wr(5'h19, 32'hC);
    wr(5'h01, 32'hF);
    rd(5'h02, 32'hFFFF_FFF0, "R2 own give");
    settle();
    pchk("R5 pad_out onehot", pad_out & 32'hFF, 32'hEF);
    pchk("R5 pad_oe periph", pad_oe & 32'hFF, 32'hFF);
    for (int k = 0; k < 4; k++) periph_out[k*N +: N] = ~(N'(1) << k);
    settle(); settle();
    pchk("R5 pad_out inverted", pad_out & 32'hFF, 32'hE0);

    // R6 pin level regardless of mux
    pad_in = 32'hA5A5_0F0F;
    rd(5'h1B, 32'hA5A5_0F0F, "R6 pin level");
    wr(5'h00, 32'hF);
    rd(5'h02, 32'hFFFF_FFFF, "R2 own take");

    // R7 open drain on pin 8
    wr(5'h0C, 32'h100);
    wr(5'h04, 32'h100);
    wr(5'h08, 32'h100);
    settle();
    pchk("R7 od high oe", pad_oe & 32'h100, 32'h0);
    pchk("R7 od high out", pad_out & 32'h100, 32'h0);
    wr(5'h09, 32'h100);
    settle();
    pchk("R7 od low oe", pad_oe & 32'h100, 32'h100);
    pchk("R7 od low out", pad_out & 32'h100, 32'h0);
    rd(5'h0E, 32'h100, "R7 od stat");
    wr(5'h0D, 32'h100);
    wr(5'h08, 32'h100);
    settle();
    pchk("R7 push-pull out", pad_out & 32'h100, 32'h100);

    // R8 / R9 pulls on pin 5
    wr(5'h14, 32'h20);
    settle();
    pchk("R9 pd masked", pad_pd & 32'h20, 32'h0);
    pchk("R9 pu kept", pad_pu & 32'h20, 32'h20);
    rd(5'h1C, 32'h20, "R9 conflict");
    rd(5'h16, 32'h20, "R8 pd stat");
    wr(5'h11, 32'h20);
    settle();
    pchk("R8 pd on", pad_pd & 32'h20, 32'h20);
    pchk("R8 pu off", pad_pu & 32'h20, 32'h0);
    rd(5'h1C, 32'h0, "R9 no conflict");
    rd(5'h12, 32'hFFFF_FFDF, "R8 pu stat");

    // R10 Schmitt register
    wr(5'h1A, 32'h1234);
    rd(5'h1A, 32'h1234, "R10 st read");
    settle();
    pchk("R10 pad_st_off", pad_st_off, 32'h1234);

    // R11 ignored writes, unmapped reads
    wr(5'h02, 32'h0);
    wr(5'h1B, 32'hFFFF);
    wr(5'h1F, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    rd(5'h02, 32'hFFFF_FFFF, "R11 own kept");
    rd(5'h06, 32'h100 | 32'hF0, "R11 oe kept");
    rd(5'h1F, 32'h0, "R11 unmapped");
    rd(5'h03, 32'h0, "R11 hole");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule